// File: doc/BRIEF.md
# Single-Cycle Core Control Decoder

This block is the purely combinational control decoder of a single-cycle integer core. It looks at the 6-bit major opcode, the 6-bit function field and the ALU zero flag of the instruction in flight. From these it produces the selects and write strobes for the datapath in the same cycle. It covers register-register add, sub, and, or and set-less-than, plus word load, word store and branch-if-equal.

The select polarity is fixed as follows:
- For the ALU second operand, high selects register rt and low selects the sign-extended immediate.
- For the write-back destination, low selects rd and high selects rt.
- For the next-PC choice, high selects the sequential PC+4 and low selects the branch target.

The ALU operation code comes from the opcode class and, for register-register instructions, from the function field. Any opcode or function field that is not supported falls back to a safe setting. In that setting nothing is written and the PC advances sequentially.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: For opcode 0x00 with a supported function field, the outputs are aluOperandSel=1, wbDestSel=0, wbFromMem=0, regWriteEn=1, memWriteEn=0 and pcSeqSel=1.
- R2: For opcode 0x23 (load word), the outputs are regWriteEn=1, wbFromMem=1, wbDestSel=1, aluOperandSel=0, memWriteEn=0, pcSeqSel=1 and aluOpSel=ADD.
- R3: For opcode 0x2B (store word), the outputs are memWriteEn=1, regWriteEn=0, aluOperandSel=0, wbFromMem=0, wbDestSel=1, pcSeqSel=1 and aluOpSel=ADD.
- R4: For opcode 0x04 (branch if equal), the outputs are regWriteEn=0, memWriteEn=0, aluOperandSel=1, wbDestSel=0, wbFromMem=0 and aluOpSel=SUB. pcSeqSel is 0 exactly when aluZero is 1.
- R5: For opcode 0x00, the function field picks aluOpSel, encoded as AND=3'b000, OR=3'b001, ADD=3'b010, SUB=3'b110 and SLT=3'b111. The mapping is 0x20 to ADD, 0x22 to SUB, 0x24 to AND, 0x25 to OR and 0x2A to SLT.
- R6: For any opcode other than 0x00, no output depends on the function field.
- R7: For any opcode other than 0x04, no output depends on aluZero, and pcSeqSel is 1.
- R8: Every opcode outside {0x00, 0x23, 0x2B, 0x04} gives regWriteEn=0, memWriteEn=0, pcSeqSel=1, aluOperandSel=1, wbDestSel=0, wbFromMem=0 and aluOpSel=ADD.
- R9: Opcode 0x00 with an unsupported function field gives regWriteEn=0, memWriteEn=0, pcSeqSel=1 and aluOpSel=ADD. The selects aluOperandSel=1, wbDestSel=0 and wbFromMem=0 are kept.
- R10: regWriteEn and memWriteEn are never high together, and wbFromMem is high only for the load opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Major opcode of the current instruction |
| funct | input | 6 | Function field of the current instruction |
| aluZero | input | 1 | ALU result-is-zero flag from the datapath |
| wbDestSel | output | 1 | Write-back destination: 0 = rd, 1 = rt |
| aluOperandSel | output | 1 | ALU second operand: 1 = rt register, 0 = immediate |
| wbFromMem | output | 1 | Write-back source: 1 = memory read data, 0 = ALU result |
| regWriteEn | output | 1 | Register file write strobe |
| memWriteEn | output | 1 | Data memory write strobe |
| pcSeqSel | output | 1 | Next PC: 1 = PC+4, 0 = branch target |
| aluOpSel | output | 3 | ALU operation code |

## Verification
The immediate assertions treat the inputs as fully known. They are evaluated only when opcode, funct and aluZero carry no X or Z bits. This lets the checker stay quiet before the stimulus first drives the pins. The stimulus changes the inputs only at clock edges and holds them stable while the outputs are sampled. It sweeps every opcode, every function field and both zero-flag values. As a result, every supported and unsupported encoding is seen with known values.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

  localparam int OpW     = 6;
  localparam int FunctW  = 6;
  localparam int AluSelW = 3;

  localparam logic [OpW-1:0] OP_REGREG = 6'h00;
  localparam logic [OpW-1:0] OP_LOADW  = 6'h23;
  localparam logic [OpW-1:0] OP_STOREW = 6'h2B;
  localparam logic [OpW-1:0] OP_BREQ   = 6'h04;

  localparam logic [FunctW-1:0] FN_ADD = 6'h20;
  localparam logic [FunctW-1:0] FN_SUB = 6'h22;
  localparam logic [FunctW-1:0] FN_AND = 6'h24;
  localparam logic [FunctW-1:0] FN_OR  = 6'h25;
  localparam logic [FunctW-1:0] FN_SLT = 6'h2A;

  typedef enum logic [AluSelW-1:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluSel_e;

  // How the ALU operation is chosen for an opcode class
  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_FUNCT = 2'd2
  } aluClass_e;

  // Strobes handed from the opcode decoder to the operation/PC logic
  typedef struct packed {
    logic      destSel;
    logic      opndSel;
    logic      fromMem;
    logic      regWr;
    logic      memWr;
    logic      branch;
    aluClass_e aluClass;
  } ctrlStrobes_t;

  localparam ctrlStrobes_t STROBES_SAFE = '{
    destSel:  1'b0,
    opndSel:  1'b1,
    fromMem:  1'b0,
    regWr:    1'b0,
    memWr:    1'b0,
    branch:   1'b0,
    aluClass: CLS_ADD
  };

endpackage

// File: rtl/sc_main_decode.sv
module sc_main_decode
  import sc_ctrl_pkg::*;
(
  input  logic [OpW-1:0] opcode,
  output ctrlStrobes_t   strobes
);

  always_comb begin
    strobes = STROBES_SAFE;
    case (opcode)
      OP_REGREG: begin
        strobes.destSel  = 1'b0;
        strobes.opndSel  = 1'b1;
        strobes.regWr    = 1'b1;
        strobes.aluClass = CLS_FUNCT;
      end
      OP_LOADW: begin
        strobes.destSel  = 1'b1;
        strobes.opndSel  = 1'b0;
        strobes.fromMem  = 1'b1;
        strobes.regWr    = 1'b1;
        strobes.aluClass = CLS_ADD;
      end
      OP_STOREW: begin
        strobes.destSel  = 1'b1;
        strobes.opndSel  = 1'b0;
        strobes.memWr    = 1'b1;
        strobes.aluClass = CLS_ADD;
      end
      OP_BREQ: begin
        strobes.opndSel  = 1'b1;
        strobes.branch   = 1'b1;
        strobes.aluClass = CLS_SUB;
      end
      default: strobes = STROBES_SAFE;
    endcase
  end

endmodule

// File: rtl/sc_alu_select.sv
module sc_alu_select
  import sc_ctrl_pkg::*;
(
  input  aluClass_e           aluClass,
  input  logic [FunctW-1:0]   funct,
  output aluSel_e             aluSel,
  output logic                functOk
);

  aluSel_e fnSel;
  logic    fnKnown;

  always_comb begin
    fnKnown = 1'b1;
    case (funct)
      FN_ADD:  fnSel = ALU_ADD;
      FN_SUB:  fnSel = ALU_SUB;
      FN_AND:  fnSel = ALU_AND;
      FN_OR:   fnSel = ALU_OR;
      FN_SLT:  fnSel = ALU_SLT;
      default: begin
        fnSel   = ALU_ADD;
        fnKnown = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (aluClass)
      CLS_SUB: begin
        aluSel  = ALU_SUB;
        functOk = 1'b1;
      end
      CLS_FUNCT: begin
        aluSel  = fnSel;
        functOk = fnKnown;
      end
      default: begin
        aluSel  = ALU_ADD;
        functOk = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sc_pc_select.sv
module sc_pc_select (
  input  logic branch,
  input  logic aluZero,
  output logic pcSeq
);

  assign pcSeq = ~(branch & aluZero);

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       aluZero,
  output logic       wbDestSel,
  output logic       aluOperandSel,
  output logic       wbFromMem,
  output logic       regWriteEn,
  output logic       memWriteEn,
  output logic       pcSeqSel,
  output logic [2:0] aluOpSel
);

  ctrlStrobes_t strobes;
  aluSel_e      aluSel;
  logic         functOk;
  logic         pcSeq;

  sc_main_decode u_main (
    .opcode  (opcode),
    .strobes (strobes)
  );

  sc_alu_select u_alu (
    .aluClass (strobes.aluClass),
    .funct    (funct),
    .aluSel   (aluSel),
    .functOk  (functOk)
  );

  sc_pc_select u_pc (
    .branch  (strobes.branch),
    .aluZero (aluZero),
    .pcSeq   (pcSeq)
  );

  assign wbDestSel     = strobes.destSel;
  assign aluOperandSel = strobes.opndSel;
  assign wbFromMem     = strobes.fromMem;
  assign regWriteEn    = strobes.regWr & functOk;
  assign memWriteEn    = strobes.memWr & functOk;
  assign pcSeqSel      = pcSeq;
  assign aluOpSel      = aluSel;

endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       aluZero,
  input logic       wbDestSel,
  input logic       aluOperandSel,
  input logic       wbFromMem,
  input logic       regWriteEn,
  input logic       memWriteEn,
  input logic       pcSeqSel,
  input logic [2:0] aluOpSel
);

  logic known;
  logic opSupported;

  assign known       = !$isunknown({opcode, funct, aluZero});
  assign opSupported = (opcode == 6'h00) || (opcode == 6'h23) ||
                       (opcode == 6'h2B) || (opcode == 6'h04);

  always_comb begin
    if (known) begin
      p_write_excl_r10: assert (!(regWriteEn && memWriteEn))
        else $error("regWriteEn and memWriteEn both high");
      p_mem_from_load_r10: assert (!wbFromMem || opcode == 6'h23)
        else $error("wbFromMem high without load");
      p_unsupported_safe_r8: assert (opSupported ||
                                     (!regWriteEn && !memWriteEn && pcSeqSel))
        else $error("unsupported opcode not safe");
      p_redirect_only_beq_r7: assert (pcSeqSel || (opcode == 6'h04 && aluZero))
        else $error("branch taken outside beq with zero");
      p_mem_addr_add_r3: assert (!(opcode == 6'h23 || opcode == 6'h2B) ||
                                 aluOpSel == 3'b010)
        else $error("memory address not computed by add");
      p_beq_sub_r4: assert (opcode != 6'h04 || aluOpSel == 3'b110)
        else $error("beq not using subtract");
    end
  end

endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk u_chk (
  .opcode        (opcode),
  .funct         (funct),
  .aluZero       (aluZero),
  .wbDestSel     (wbDestSel),
  .aluOperandSel (aluOperandSel),
  .wbFromMem     (wbFromMem),
  .regWriteEn    (regWriteEn),
  .memWriteEn    (memWriteEn),
  .pcSeqSel      (pcSeqSel),
  .aluOpSel      (aluOpSel)
);

// File: tb/sc_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module sc_ctrl_decoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       aluZero;
  logic       wbDestSel, aluOperandSel, wbFromMem;
  logic       regWriteEn, memWriteEn, pcSeqSel;
  logic [2:0] aluOpSel;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sc_ctrl_decoder u_dut (
    .opcode        (opcode),
    .funct         (funct),
    .aluZero       (aluZero),
    .wbDestSel     (wbDestSel),
    .aluOperandSel (aluOperandSel),
    .wbFromMem     (wbFromMem),
    .regWriteEn    (regWriteEn),
    .memWriteEn    (memWriteEn),
    .pcSeqSel      (pcSeqSel),
    .aluOpSel      (aluOpSel)
  );

  // Packed expectation: {dest, opnd, fromMem, rw, mw, pcSeq, aluOp[2:0]}
  function automatic logic [8:0] expected(input logic [5:0] op,
                                          input logic [5:0] fn,
                                          input logic z);
    logic [2:0] fnOp;
    logic       fnOk;
    fnOk = 1'b1;
    case (fn)
      6'h20: fnOp = 3'b010;
      6'h22: fnOp = 3'b110;
      6'h24: fnOp = 3'b000;
      6'h25: fnOp = 3'b001;
      6'h2A: fnOp = 3'b111;
      default: begin fnOp = 3'b010; fnOk = 1'b0; end
    endcase
    case (op)
      6'h00:   return {1'b0, 1'b1, 1'b0, fnOk, 1'b0, 1'b1, fnOp};  // R1 R5 R9
      6'h23:   return {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010}; // R2
      6'h2B:   return {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b010}; // R3
      6'h04:   return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ~z, 3'b110};   // R4
      default: return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010}; // R8
    endcase
  endfunction

  function automatic string reqTag(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: begin
        if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)
          return "R1 R5";
        return "R9";
      end
      6'h23:   return "R2 R6 R7";
      6'h2B:   return "R3 R6 R7";
      6'h04:   return "R4 R6";
      default: return "R8 R6 R7";
    endcase
  endfunction

  task automatic checkNow(input string tag);
    logic [8:0] exp;
    logic [8:0] act;
    exp = expected(opcode, funct, aluZero);
    act = {wbDestSel, aluOperandSel, wbFromMem, regWriteEn, memWriteEn,
           pcSeqSel, aluOpSel};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%h fn=%h z=%0b actual=%b expected=%b",
               tag, opcode, funct, aluZero, act, exp);
    end
    checks++;
    if (regWriteEn === 1'b1 && memWriteEn === 1'b1) begin
      failures++;
      $display("FAIL R10 op=%h actual rw=1 mw=1 expected not both", opcode);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset-time state: an unsupported opcode must be safe (R8)
    opcode = 6'h3F; funct = 6'h00; aluZero = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkNow("R8 reset");
    rst = 1'b0;

    // Directed corners
    @(posedge clk); opcode = 6'h04; funct = 6'h20; aluZero = 1'b1;
    @(negedge clk); checkNow("R4 taken");
    @(posedge clk); aluZero = 1'b0;
    @(negedge clk); checkNow("R4 not taken");
    @(posedge clk); opcode = 6'h00; funct = 6'h2A; aluZero = 1'b1;
    @(negedge clk); checkNow("R5 slt with zero R7");
    @(posedge clk); funct = 6'h21;
    @(negedge clk); checkNow("R9 bad funct");
    @(posedge clk); opcode = 6'h23; funct = 6'h3F;
    @(negedge clk); checkNow("R2 R6 junk funct");
    @(posedge clk); opcode = 6'h2B; funct = 6'h22; aluZero = 1'b0;
    @(negedge clk); checkNow("R3 R6 sub funct");

    // Exhaustive sweep
    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        for (int z = 0; z < 2; z++) begin
          @(posedge clk);
          opcode  = o[5:0];
          funct   = f[5:0];
          aluZero = z[0];
          @(negedge clk);
          checkNow(reqTag(o[5:0], f[5:0]));
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule